// File: doc/BRIEF.md
# Banked Special-Register File with Stack Selection

This block keeps the special registers of a small microcontroller core: two stack pointers (main and process), a composite 32-bit status word made of three disjoint fields (condition flags, active exception number, instruction-set state bit), a one-bit priority mask and a two-bit control register.

Software reaches these registers through a register-move port. A 4-bit selector code names the register, and reads are combinational. The core also supplies its current mode (Thread or Handler) and pulses an exception entry or exception return strobe. The block decides which stack pointer is active. It reports that pointer, a priority-mask output, the Thread-mode privilege level, and a fault request whenever the state bit is clear.

At reset the main stack pointer is taken from the initial stack vector word and the state bit from bit 0 of the reset vector word. Every read and write rule depends on the mode: the state field is never visible to software, and in Handler mode the stack-select bit is hidden.

Top module: `spreg_file`

## Requirements
- R1: While `rst` is high at a clock edge, the following happen. The main stack pointer takes `vec_sp` with bits 1:0 cleared. The state bit takes `vec_pc[0]`. The process stack pointer, the flags, the exception number, the priority mask and both control bits become 0.
- R2: When `handler_mode` is 0, control bit 1 (stack select) chooses the pointer: 0 selects main and 1 selects process. When `handler_mode` is 1, the main pointer is always used. `sp_active` shows the chosen pointer and `sp_is_psp` is high only when the process pointer is chosen.
- R3: Selector 11 accesses the control register, with bit 1 as stack select and bit 0 as privilege.
  - In Handler mode, stack select reads as 0 and a write to it is ignored.
  - In Thread mode, a write to it takes effect.
- R4: Control bit 0 is read/write, and 1 means unprivileged. It drives `thread_unpriv`. When parameter `PRIV_EN` is 0, the bit reads as 0 and cannot be set.
- R5: The selector codes for the status word are: 0 flags, 1 exception number, 2 state, 3 flags+exception, 4 flags+state, 5 exception+state, 6 all three.
  - A read returns the chosen fields at their positions: flags N,Z,C,V at bits 31:28, state bit at bit 24, exception number at bits 5:0.
  - All other bits read as zero.
  - Selectors 7 and 12 to 15 read zero and ignore writes.
- R6: The state bit always reads as zero through the port. Software writes never change it; this is visible through `t_fault`.
- R7: The exception number cannot be written by software. An exception entry stores `exc_entry_num` and loads the state bit from `exc_entry_t`.
- R8: Selector 10 accesses the priority mask at bit 0. `prio_masked` equals the stored mask bit.
- R9: An exception return loads the flags, the state bit and the exception number from the corresponding fields of `exc_ret_psr`. `t_fault` is high exactly when the state bit is 0.
- R10: Selectors 8 and 9 access the main and process stack pointers. Writes store the data with bits 1:0 forced to zero.
- R11: When strobes coincide on the status word, an exception return beats an exception entry, and an entry beats a software flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_sp | input | 32 | Initial stack vector word, loaded at reset |
| vec_pc | input | 32 | Reset vector word; bit 0 gives the state bit |
| handler_mode | input | 1 | 1 = Handler mode, 0 = Thread mode |
| mv_sel | input | 4 | Register selector code |
| mv_we | input | 1 | Write strobe for the selected register |
| mv_wdata | input | 32 | Write data |
| mv_rdata | output | 32 | Combinational read data for the selected register |
| exc_entry | input | 1 | Exception entry strobe |
| exc_entry_num | input | 6 | Exception number being entered |
| exc_entry_t | input | 1 | Bit 0 of the handler vector word |
| exc_return | input | 1 | Exception return strobe |
| exc_ret_psr | input | 32 | Stacked status word to restore |
| sp_active | output | 32 | Currently selected stack pointer value |
| sp_is_psp | output | 1 | High when the process stack pointer is active |
| prio_masked | output | 1 | Configurable-priority exceptions are blocked |
| thread_unpriv | output | 1 | Thread mode runs unprivileged |
| t_fault | output | 1 | State bit is clear; fault request |

## Verification
The bench builds two copies of the block from the same stimulus: one with `PRIV_EN` set to 1 and one with it set to 0. Comparing them shows the privilege bit being writable in one copy and stuck at zero in the other, while every other register behaves identically. Each copy is swept across all sixteen selector codes after every operation. This exposes the mode-dependent hiding of stack select, the always-zero state field and the unused codes. Random coinciding strobes reach the return/entry/write ordering.

// File: rtl/spreg_pkg.sv
package spreg_pkg;

    localparam int XLEN    = 32;
    localparam int EXC_W   = 6;
    localparam int FLAG_LO = 28;
    localparam int TBIT_POS = 24;

    typedef enum logic [3:0] {
        SEL_FLAGS   = 4'd0,
        SEL_EXC     = 4'd1,
        SEL_STATE   = 4'd2,
        SEL_FL_EXC  = 4'd3,
        SEL_FL_ST   = 4'd4,
        SEL_EXC_ST  = 4'd5,
        SEL_ALLST   = 4'd6,
        SEL_MSP     = 4'd8,
        SEL_PSP     = 4'd9,
        SEL_PMASK   = 4'd10,
        SEL_CTRL    = 4'd11
    } sel_e;

    typedef struct packed {
        logic [3:0]       flags;
        logic             tbit;
        logic [EXC_W-1:0] exc;
    } status_t;

    function automatic logic sel_has_flags(input logic [3:0] s);
        return (s == SEL_FLAGS) || (s == SEL_FL_EXC) ||
               (s == SEL_FL_ST) || (s == SEL_ALLST);
    endfunction

    function automatic logic sel_has_exc(input logic [3:0] s);
        return (s == SEL_EXC) || (s == SEL_FL_EXC) ||
               (s == SEL_EXC_ST) || (s == SEL_ALLST);
    endfunction

    // Software view of the status word: the state bit is never exposed.
    function automatic logic [XLEN-1:0] status_view(input status_t st,
                                                    input logic [3:0] s);
        logic [XLEN-1:0] w;
        w = '0;
        if (sel_has_flags(s)) w[XLEN-1:FLAG_LO] = st.flags;
        if (sel_has_exc(s))   w[EXC_W-1:0]      = st.exc;
        return w;
    endfunction

endpackage

// File: rtl/spreg_status.sv
module spreg_status
    import spreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_t,
    input  logic [3:0]      sel,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    input  logic            entry,
    input  logic [EXC_W-1:0] entry_num,
    input  logic            entry_t,
    input  logic            ret,
    input  logic [XLEN-1:0] ret_psr,
    output status_t         st
);

    status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flags <= '0;
            st_q.tbit  <= rst_t;
            st_q.exc   <= '0;
        end else if (ret) begin
            st_q.flags <= ret_psr[XLEN-1:FLAG_LO];
            st_q.tbit  <= ret_psr[TBIT_POS];
            st_q.exc   <= ret_psr[EXC_W-1:0];
        end else if (entry) begin
            st_q.exc   <= entry_num;
            st_q.tbit  <= entry_t;
        end else if (we && sel_has_flags(sel)) begin
            st_q.flags <= wdata[XLEN-1:FLAG_LO];
        end
    end

    assign st = st_q;

    assert_ret_restore_R9: assert property (@(posedge clk) disable iff (rst)
        ret |=> (st.flags == $past(ret_psr[XLEN-1:FLAG_LO])) &&
                (st.tbit == $past(ret_psr[TBIT_POS])) &&
                (st.exc == $past(ret_psr[EXC_W-1:0])));

    assert_exc_readonly_R7: assert property (@(posedge clk) disable iff (rst)
        (!entry && !ret) |=> $stable(st.exc) && $stable(st.tbit));

    assert_entry_order_R11: assert property (@(posedge clk) disable iff (rst)
        (entry && !ret) |=> (st.exc == $past(entry_num)) &&
                            $stable(st.flags));

endmodule

// File: rtl/spreg_stack.sv
module spreg_stack
    import spreg_pkg::*;
#(
    parameter bit PRIV_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] rst_sp,
    input  logic            handler,
    input  logic [3:0]      sel,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] msp,
    output logic [XLEN-1:0] psp,
    output logic            spsel,
    output logic            npriv,
    output logic [XLEN-1:0] sp_active,
    output logic            sp_is_psp
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(3));

    logic [XLEN-1:0] msp_q, psp_q;
    logic            spsel_q, npriv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msp_q   <= rst_sp & ALIGN_MASK;
            psp_q   <= '0;
            spsel_q <= 1'b0;
        end else if (we) begin
            if (sel == SEL_MSP) msp_q <= wdata & ALIGN_MASK;
            if (sel == SEL_PSP) psp_q <= wdata & ALIGN_MASK;
            if (sel == SEL_CTRL && !handler) spsel_q <= wdata[1];
        end
    end

    generate
        if (PRIV_EN) begin : g_priv
            always_ff @(posedge clk) begin
                if (rst)                        npriv_q <= 1'b0;
                else if (we && sel == SEL_CTRL) npriv_q <= wdata[0];
            end
        end else begin : g_nopriv
            assign npriv_q = 1'b0;
        end
    endgenerate

    assign msp       = msp_q;
    assign psp       = psp_q;
    assign spsel     = spsel_q;
    assign npriv     = npriv_q;
    assign sp_is_psp = spsel_q && !handler;
    assign sp_active = sp_is_psp ? psp_q : msp_q;

    assert_handler_uses_main_R2: assert property (@(posedge clk) disable iff (rst)
        handler |-> (sp_active == msp));

    assert_spsel_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (handler && we && sel == SEL_CTRL) |=> $stable(spsel));

    assert_sp_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (msp[1:0] == 2'b00) && (psp[1:0] == 2'b00));

endmodule

// File: rtl/spreg_mask.sv
module spreg_mask
    import spreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      sel,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic            pmask
);

    logic pmask_q;

    always_ff @(posedge clk) begin
        if (rst)                         pmask_q <= 1'b0;
        else if (we && sel == SEL_PMASK) pmask_q <= wdata[0];
    end

    assign pmask = pmask_q;

    assert_pmask_write_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_PMASK) |=> (pmask == $past(wdata[0])));

endmodule

// File: rtl/spreg_file.sv
module spreg_file
    import spreg_pkg::*;
#(
    parameter bit PRIV_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   vec_sp,
    input  logic [XLEN-1:0]   vec_pc,
    input  logic              handler_mode,
    input  logic [3:0]        mv_sel,
    input  logic              mv_we,
    input  logic [XLEN-1:0]   mv_wdata,
    output logic [XLEN-1:0]   mv_rdata,
    input  logic              exc_entry,
    input  logic [EXC_W-1:0]  exc_entry_num,
    input  logic              exc_entry_t,
    input  logic              exc_return,
    input  logic [XLEN-1:0]   exc_ret_psr,
    output logic [XLEN-1:0]   sp_active,
    output logic              sp_is_psp,
    output logic              prio_masked,
    output logic              thread_unpriv,
    output logic              t_fault
);

    status_t         st;
    logic [XLEN-1:0] msp, psp;
    logic            spsel, npriv, pmask;

    spreg_status u_status (
        .clk      (clk),
        .rst      (rst),
        .rst_t    (vec_pc[0]),
        .sel      (mv_sel),
        .we       (mv_we),
        .wdata    (mv_wdata),
        .entry    (exc_entry),
        .entry_num(exc_entry_num),
        .entry_t  (exc_entry_t),
        .ret      (exc_return),
        .ret_psr  (exc_ret_psr),
        .st       (st)
    );

    spreg_stack #(.PRIV_EN(PRIV_EN)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .rst_sp   (vec_sp),
        .handler  (handler_mode),
        .sel      (mv_sel),
        .we       (mv_we),
        .wdata    (mv_wdata),
        .msp      (msp),
        .psp      (psp),
        .spsel    (spsel),
        .npriv    (npriv),
        .sp_active(sp_active),
        .sp_is_psp(sp_is_psp)
    );

    spreg_mask u_mask (
        .clk  (clk),
        .rst  (rst),
        .sel  (mv_sel),
        .we   (mv_we),
        .wdata(mv_wdata),
        .pmask(pmask)
    );

    always_comb begin
        mv_rdata = status_view(st, mv_sel);
        case (mv_sel)
            SEL_MSP:   mv_rdata = msp;
            SEL_PSP:   mv_rdata = psp;
            SEL_PMASK: mv_rdata = {{(XLEN-1){1'b0}}, pmask};
            SEL_CTRL:  mv_rdata = {{(XLEN-2){1'b0}}, spsel & ~handler_mode, npriv};
            default:   ;
        endcase
    end

    assign prio_masked   = pmask;
    assign thread_unpriv = npriv;
    assign t_fault       = ~st.tbit;

    assert_state_hidden_R6: assert property (@(posedge clk) disable iff (rst)
        (mv_sel == SEL_STATE) |-> (mv_rdata == '0));

    assert_tfault_after_return_R9: assert property (@(posedge clk) disable iff (rst)
        exc_return |=> (t_fault == !$past(exc_ret_psr[TBIT_POS])));

    assert_ctrl_handler_read_R3: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && mv_sel == SEL_CTRL) |-> (mv_rdata[1] == 1'b0));

endmodule

// File: tb/test_spreg_file.sv
`timescale 1ns/100ps
module test_spreg_file;

    localparam real CLK_PERIOD = 10.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vec_sp = 32'h2000_1003;
    logic [31:0] vec_pc = 32'h0000_0105;
    logic        handler_mode = 1'b0;
    logic [3:0]  mv_sel = 4'd0;
    logic        mv_we = 1'b0;
    logic [31:0] mv_wdata = '0;
    logic        exc_entry = 1'b0;
    logic [5:0]  exc_entry_num = '0;
    logic        exc_entry_t = 1'b1;
    logic        exc_return = 1'b0;
    logic [31:0] exc_ret_psr = '0;

    logic [31:0] rd_a, sp_a, rd_b, sp_b;
    logic        psp_a, pm_a, up_a, tf_a, psp_b, pm_b, up_b, tf_b;

    int total = 0;
    int bad = 0;

    // reference state
    logic [31:0] m_msp, m_psp;
    logic [3:0]  m_flags;
    logic        m_t, m_pm, m_spsel, m_npriv;
    logic [5:0]  m_exc;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    spreg_file #(.PRIV_EN(1'b1)) i_spreg_file (
        .clk(clk), .rst(rst), .vec_sp(vec_sp), .vec_pc(vec_pc),
        .handler_mode(handler_mode), .mv_sel(mv_sel), .mv_we(mv_we),
        .mv_wdata(mv_wdata), .mv_rdata(rd_a), .exc_entry(exc_entry),
        .exc_entry_num(exc_entry_num), .exc_entry_t(exc_entry_t),
        .exc_return(exc_return), .exc_ret_psr(exc_ret_psr),
        .sp_active(sp_a), .sp_is_psp(psp_a), .prio_masked(pm_a),
        .thread_unpriv(up_a), .t_fault(tf_a));

    spreg_file #(.PRIV_EN(1'b0)) i_spreg_file_np (
        .clk(clk), .rst(rst), .vec_sp(vec_sp), .vec_pc(vec_pc),
        .handler_mode(handler_mode), .mv_sel(mv_sel), .mv_we(mv_we),
        .mv_wdata(mv_wdata), .mv_rdata(rd_b), .exc_entry(exc_entry),
        .exc_entry_num(exc_entry_num), .exc_entry_t(exc_entry_t),
        .exc_return(exc_return), .exc_ret_psr(exc_ret_psr),
        .sp_active(sp_b), .sp_is_psp(psp_b), .prio_masked(pm_b),
        .thread_unpriv(up_b), .t_fault(tf_b));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] s, input logic h,
                                             input logic pe);
        logic [31:0] w;
        w = '0;
        if (s inside {4'd0, 4'd3, 4'd4, 4'd6}) w[31:28] = m_flags;
        if (s inside {4'd1, 4'd3, 4'd5, 4'd6}) w[5:0]   = m_exc;
        case (s)
            4'd8:  w = m_msp;
            4'd9:  w = m_psp;
            4'd10: w = {31'b0, m_pm};
            4'd11: w = {30'b0, m_spsel & ~h, m_npriv & pe};
            default: ;
        endcase
        return w;
    endfunction

    function automatic string req_of(input logic [3:0] s);
        if (s == 4'd2) return "R6";
        if (s <= 4'd6) return "R5";
        if (s == 4'd8 || s == 4'd9) return "R10";
        if (s == 4'd10) return "R8";
        if (s == 4'd11) return "R3/R4";
        return "R5";
    endfunction

    task automatic sweep();
        logic [3:0] keep;
        logic       use_psp;
        keep = mv_sel;
        for (int s = 0; s < 16; s++) begin
            mv_sel = 4'(s);
            #0.2;
            chk(req_of(4'(s)), "read A", rd_a, exp_read(4'(s), handler_mode, 1'b1));
            chk(req_of(4'(s)), "read B", rd_b, exp_read(4'(s), handler_mode, 1'b0));
        end
        mv_sel = keep;
        #0.2;
        use_psp = m_spsel && !handler_mode;
        chk("R2", "sp_is_psp", {31'b0, psp_a}, {31'b0, use_psp});
        chk("R2", "sp_active", sp_a, use_psp ? m_psp : m_msp);
        chk("R8", "prio_masked", {31'b0, pm_a}, {31'b0, m_pm});
        chk("R4", "thread_unpriv A", {31'b0, up_a}, {31'b0, m_npriv});
        chk("R4", "thread_unpriv B", {31'b0, up_b}, 32'd0);
        chk("R9", "t_fault", {31'b0, tf_a}, {31'b0, ~m_t});
        chk("R9", "t_fault B", {31'b0, tf_b}, {31'b0, ~m_t});
    endtask

    // One clock of stimulus; reference updated from the requirements.
    task automatic op(input logic h, input logic we, input logic [3:0] s,
                      input logic [31:0] wd, input logic en, input logic [5:0] num,
                      input logic et, input logic rt, input logic [31:0] psr);
        @(negedge clk);
        handler_mode = h; mv_we = we; mv_sel = s; mv_wdata = wd;
        exc_entry = en; exc_entry_num = num; exc_entry_t = et;
        exc_return = rt; exc_ret_psr = psr;
        @(posedge clk);
        if (rt) begin                       // R11: return first
            m_flags = psr[31:28]; m_t = psr[24]; m_exc = psr[5:0];
        end else if (en) begin              // R7
            m_exc = num; m_t = et;
        end else if (we && (s inside {4'd0, 4'd3, 4'd4, 4'd6})) begin
            m_flags = wd[31:28];
        end
        if (we) begin
            if (s == 4'd8)  m_msp = wd & ~32'd3;
            if (s == 4'd9)  m_psp = wd & ~32'd3;
            if (s == 4'd10) m_pm = wd[0];
            if (s == 4'd11) begin
                m_npriv = wd[0];
                if (!h) m_spsel = wd[1];
            end
        end
        @(negedge clk);
        mv_we = 1'b0; exc_entry = 1'b0; exc_return = 1'b0;
        sweep();
    endtask

    function automatic logic [5:0] pick_exc();
        case ($urandom % 6)
            0: return 6'd2;
            1: return 6'd3;
            2: return 6'd11;
            3: return 6'd14;
            4: return 6'd15;
            default: return 6'(16 + ($urandom % 32));
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset loads vectors
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_msp = 32'h2000_1000; m_psp = '0; m_flags = '0; m_t = 1'b1;
        m_exc = '0; m_pm = 1'b0; m_spsel = 1'b0; m_npriv = 1'b0;
        chk("R1", "msp after reset", sp_a, 32'h2000_1000);
        chk("R1", "t_fault after reset", {31'b0, tf_a}, 32'd0);
        sweep();

        // R10: pointer writes drop low bits
        op(1'b0, 1'b1, 4'd9, 32'h1000_0FFF, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        op(1'b0, 1'b1, 4'd8, 32'h2000_2002, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        // R2/R4: Thread selects process pointer, unprivileged
        op(1'b0, 1'b1, 4'd11, 32'h0000_0003, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        chk("R2", "thread process sp", sp_a, 32'h1000_0FFC);
        // R2: Handler forces main pointer
        op(1'b1, 1'b0, 4'd0, '0, 1'b1, 6'd11, 1'b1, 1'b0, '0);
        chk("R2", "handler main sp", sp_a, 32'h2000_2000);
        // R3: Handler write to stack select ignored
        op(1'b1, 1'b1, 4'd11, 32'h0000_0000, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        op(1'b0, 1'b0, 4'd0, '0, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        chk("R3", "spsel kept", {31'b0, psp_a}, 32'd1);
        // R6: writes to state field ignored
        op(1'b0, 1'b1, 4'd6, 32'hF000_003F, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        op(1'b0, 1'b1, 4'd2, 32'h0000_0000, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        chk("R6", "t bit unchanged by write", {31'b0, tf_a}, 32'd0);
        // R9: return with T clear raises fault, then restore
        op(1'b1, 1'b0, 4'd0, '0, 1'b0, 6'd0, 1'b1, 1'b1, 32'h5000_0010);
        chk("R9", "fault on T=0", {31'b0, tf_a}, 32'd1);
        op(1'b1, 1'b0, 4'd0, '0, 1'b0, 6'd0, 1'b1, 1'b1, 32'hA100_0000);
        // R11: all strobes together
        op(1'b1, 1'b1, 4'd0, 32'h3000_0000, 1'b1, 6'd20, 1'b0, 1'b1, 32'h9100_0005);
        op(1'b1, 1'b1, 4'd0, 32'h3000_0000, 1'b1, 6'd20, 1'b0, 1'b0, '0);
        // R8: priority mask
        op(1'b0, 1'b1, 4'd10, 32'hFFFF_FFFF, 1'b0, 6'd0, 1'b1, 1'b0, '0);
        chk("R8", "mask set", {31'b0, pm_a}, 32'd1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] psr;
            psr = $urandom;
            if (($urandom % 4) != 0) psr[24] = 1'b1;
            op(1'($urandom % 2), 1'(($urandom % 3) != 0), 4'($urandom % 16), $urandom,
               1'(($urandom % 5) == 0), pick_exc(), 1'(($urandom % 6) != 0),
               1'(($urandom % 7) == 0), psr);
        end

        // R1: second reset with T clear in the vector
        @(negedge clk);
        rst = 1'b1; vec_sp = 32'h3000_0007; vec_pc = 32'h0000_0200;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_msp = 32'h3000_0004; m_psp = '0; m_flags = '0; m_t = 1'b0;
        m_exc = '0; m_pm = 1'b0; m_spsel = 1'b0; m_npriv = 1'b0;
        handler_mode = 1'b0;
        sweep();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule